// File: doc/BRIEF.md
# Register Redirection Lookup Table

This block holds a small set of programmable configuration entries. Each entry says that an integer or floating-point register number, when it appears as a source or destination operand, gets special treatment. That treatment is a vector/scalar choice, an element-width code, a packed-lanes flag, a bank bit and a predicate index that is passed through unchanged. Software loads entries one at a time through a registered write port that takes an entry address and a 16-bit data word.

Decode logic presents register numbers to two independent combinational lookup ports, one for the integer space and one for the floating-point space. Each port searches every entry associatively and returns the attributes of the winning entry. If no entry matches, the port returns a plain scalar default. When several entries claim the same key, the highest-numbered entry decides the result.

Top module: `redir_lookup_table`

## Requirements
- R1: After reset every entry is invalid, so no key in either space reports a hit until an entry has been written.
- R2: A write (wr_en high at a rising edge, wr_addr selecting the entry) takes effect at that edge. A lookup made in the same cycle as the write still sees the previous contents, and lookups from the following cycle see the new entry.
- R3: Entry word layout: bit 15 packed flag, bit 14 bank, bit 13 vector flag, bits 12..11 width code, bit 10 space, bits 9..5 register key, bits 4..0 predicate index. A valid entry matches a lookup when its key field equals the presented register number and its space bit equals the port's space. On a match the port reports hit=1, idx equal to the key field, and vec, ew, simd and pred copied from the entry, with bank=0.
- R4: Space bit 0 means integer and 1 means floating point. An integer entry never hits on the floating-point port, and a floating-point entry never hits on the integer port.
- R5: An entry whose bank bit (bit 14) is 1 is reserved and never matches, whatever its other fields hold.
- R6: When several valid entries match the same key in the same space, the result comes from the highest-numbered of them.
- R7: When nothing matches, the port reports hit=0, idx equal to the presented register number, vec=0, ew=0, simd=0, bank=0 and pred=0.
- R8: The two ports work independently in the same cycle. Each returns its own space's result for its own register number.
- R9: Rewriting an entry fully replaces its old contents, so the old key stops hitting through that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | ADDR_W (4) | Entry number to write |
| wr_data | input | 16 | Entry word |
| int_reg | input | 5 | Integer register number to look up |
| int_hit | output | 1 | Integer lookup matched |
| int_idx | output | 5 | Integer redirected index |
| int_vec | output | 1 | Integer result is vector |
| int_ew | output | 2 | Integer width code |
| int_simd | output | 1 | Integer packed flag |
| int_bank | output | 1 | Integer bank bit |
| int_pred | output | 5 | Integer predicate index |
| fp_reg | input | 5 | Floating-point register number to look up |
| fp_hit | output | 1 | Floating-point lookup matched |
| fp_idx | output | 5 | Floating-point redirected index |
| fp_vec | output | 1 | Floating-point result is vector |
| fp_ew | output | 2 | Floating-point width code |
| fp_simd | output | 1 | Floating-point packed flag |
| fp_bank | output | 1 | Floating-point bank bit |
| fp_pred | output | 5 | Floating-point predicate index |

## Verification
An entry write and a lookup of the same key can happen in one cycle. The bench provokes this by presenting the key being written on the ports while wr_en is high. It expects the results from before the write in that cycle and the new entry's attributes in the next cycle. The two lookup ports are also driven together with the same register number while entries exist for both spaces, so that any crossing between spaces shows up.

// File: rtl/redir_pkg.sv
package redir_pkg;

   localparam int REG_W = 5;

   typedef struct packed {
      logic             simd;
      logic             bank;
      logic             vec;
      logic [1:0]       ew;
      logic             fp;
      logic [REG_W-1:0] key;
      logic [REG_W-1:0] pidx;
   } redir_entry_t;

   localparam int ENTRY_BITS = $bits(redir_entry_t);

   typedef struct packed {
      logic             hit;
      logic [REG_W-1:0] idx;
      logic             vec;
      logic [1:0]       ew;
      logic             simd;
      logic             bank;
      logic [REG_W-1:0] pidx;
   } redir_result_t;

endpackage

// File: rtl/redir_entry_store.sv
module redir_entry_store
   import redir_pkg::*;
#(
   parameter int ADDR_W = 4,
   localparam int NUM_ENTRIES = 1 << ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  redir_entry_t                   wr_data,
   output redir_entry_t [NUM_ENTRIES-1:0] entries_o,
   output logic [NUM_ENTRIES-1:0]         valid_o
);

   redir_entry_t [NUM_ENTRIES-1:0] entries_q;
   logic [NUM_ENTRIES-1:0]         valid_q;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_addr == ADDR_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries_q[e] <= '0;
            valid_q[e]   <= 1'b0;
         end else if (sel) begin
            entries_q[e] <= wr_data;
            valid_q[e]   <= 1'b1;
         end
      end
   end

   assign entries_o = entries_q;
   assign valid_o   = valid_q;

   // R2: contents only move when a write is issued
   a_r2_hold_contents: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(entries_q));

   a_r2_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q));

   // R2: the addressed entry holds the written word one edge later
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_addr)] && entries_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/redir_match_port.sv
module redir_match_port
   import redir_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter bit SPACE_FP = 1'b0,
   localparam int NUM_ENTRIES = 1 << ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  redir_entry_t [NUM_ENTRIES-1:0] entries_i,
   input  logic [NUM_ENTRIES-1:0]         valid_i,
   input  logic [REG_W-1:0]               key_i,
   output redir_result_t                  res_o
);

   logic [NUM_ENTRIES-1:0] match;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
      assign match[e] = valid_i[e]
                        && !entries_i[e].bank
                        && (entries_i[e].fp == SPACE_FP)
                        && (entries_i[e].key == key_i);
   end

   // ascending scan: a later (higher) match overrides an earlier one
   always_comb begin
      res_o      = '0;
      res_o.idx  = key_i;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (match[e]) begin
            res_o.hit  = 1'b1;
            res_o.idx  = entries_i[e].key;
            res_o.vec  = entries_i[e].vec;
            res_o.ew   = entries_i[e].ew;
            res_o.simd = entries_i[e].simd;
            res_o.bank = entries_i[e].bank;
            res_o.pidx = entries_i[e].pidx;
         end
      end
   end

   // R3: a hit always names the presented register
   a_r3_hit_index: assert property (@(posedge clk) disable iff (!rst_n)
      res_o.hit |-> (res_o.idx == key_i));

   // R5: reserved bank never leaks to a hit
   a_r5_bank_clear: assert property (@(posedge clk) disable iff (!rst_n)
      res_o.hit |-> !res_o.bank);

   // R7: a miss returns the plain scalar default
   a_r7_miss_default: assert property (@(posedge clk) disable iff (!rst_n)
      !res_o.hit |-> (res_o.idx == key_i && !res_o.vec && res_o.ew == 2'd0
                      && !res_o.simd && !res_o.bank && res_o.pidx == '0));

endmodule

// File: rtl/redir_lookup_table.sv
module redir_lookup_table
   import redir_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int ENTRY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [4:0]        int_reg,
   output logic              int_hit,
   output logic [4:0]        int_idx,
   output logic              int_vec,
   output logic [1:0]        int_ew,
   output logic              int_simd,
   output logic              int_bank,
   output logic [4:0]        int_pred,
   input  logic [4:0]        fp_reg,
   output logic              fp_hit,
   output logic [4:0]        fp_idx,
   output logic              fp_vec,
   output logic [1:0]        fp_ew,
   output logic              fp_simd,
   output logic              fp_bank,
   output logic [4:0]        fp_pred
);

   localparam int NUM_ENTRIES = 1 << ADDR_W;
   localparam int NUM_SPACES  = 2;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end
   if (ENTRY_W != ENTRY_BITS) begin : g_bad_width
      $error("ENTRY_W must equal the packed entry size");
   end

   redir_entry_t [NUM_ENTRIES-1:0] entries;
   logic [NUM_ENTRIES-1:0]         valid;
   logic [REG_W-1:0]               keys [NUM_SPACES];
   redir_result_t                  res  [NUM_SPACES];

   redir_entry_store #(.ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (redir_entry_t'(wr_data)),
      .entries_o(entries),
      .valid_o  (valid)
   );

   assign keys[0] = int_reg;
   assign keys[1] = fp_reg;

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      redir_match_port #(.ADDR_W(ADDR_W), .SPACE_FP(s == 1)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .entries_i(entries),
         .valid_i  (valid),
         .key_i    (keys[s]),
         .res_o    (res[s])
      );
   end

   assign int_hit  = res[0].hit;
   assign int_idx  = res[0].idx;
   assign int_vec  = res[0].vec;
   assign int_ew   = res[0].ew;
   assign int_simd = res[0].simd;
   assign int_bank = res[0].bank;
   assign int_pred = res[0].pidx;

   assign fp_hit   = res[1].hit;
   assign fp_idx   = res[1].idx;
   assign fp_vec   = res[1].vec;
   assign fp_ew    = res[1].ew;
   assign fp_simd  = res[1].simd;
   assign fp_bank  = res[1].bank;
   assign fp_pred  = res[1].pidx;

   // R1: the cycle after reset release nothing can hit
   a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!int_hit && !fp_hit));

endmodule

// File: tb/sim_redir_lookup_table.sv
module sim_redir_lookup_table;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0] int_reg = '0, fp_reg = '0;
   logic       int_hit, int_vec, int_simd, int_bank;
   logic       fp_hit, fp_vec, fp_simd, fp_bank;
   logic [4:0] int_idx, int_pred, fp_idx, fp_pred;
   logic [1:0] int_ew, fp_ew;

   always #2.5 clk = ~clk;

   redir_lookup_table u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .int_reg(int_reg), .int_hit(int_hit), .int_idx(int_idx), .int_vec(int_vec),
      .int_ew(int_ew), .int_simd(int_simd), .int_bank(int_bank), .int_pred(int_pred),
      .fp_reg(fp_reg), .fp_hit(fp_hit), .fp_idx(fp_idx), .fp_vec(fp_vec),
      .fp_ew(fp_ew), .fp_simd(fp_simd), .fp_bank(fp_bank), .fp_pred(fp_pred)
   );

   // result packed as {hit, idx[4:0], vec, ew[1:0], simd, bank, pred[4:0]}
   typedef struct {
      logic [15:0] ires;
      logic [15:0] fres;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   logic [15:0] mdl [16];
   bit          mval [16];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   function automatic logic [15:0] model(input logic [4:0] key, input bit fp);
      logic [15:0] r;
      r = {1'b0, key, 10'd0};
      for (int i = 0; i < 16; i++) begin
         if (mval[i] && !mdl[i][14] && mdl[i][10] == fp && mdl[i][9:5] == key)
            r = {1'b1, mdl[i][9:5], mdl[i][13], mdl[i][12:11], mdl[i][15], 1'b0, mdl[i][4:0]};
      end
      return r;
   endfunction

   function automatic logic [15:0] ent(input bit simd, input bit bank, input bit vec,
                                       input logic [1:0] ew, input bit fp,
                                       input logic [4:0] key, input logic [4:0] pidx);
      return {simd, bank, vec, ew, fp, key, pidx};
   endfunction

   // driver: one cycle of stimulus, optional write, expected pushed before the model moves
   task automatic step(input bit we, input logic [3:0] a, input logic [15:0] d,
                       input logic [4:0] ik, input logic [4:0] fk, input string tag);
      exp_t x;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      int_reg = ik; fp_reg = fk;
      x.ires = model(ik, 1'b0);
      x.fres = model(fk, 1'b1);
      x.tag  = tag;
      sbq.push_back(x);
      if (we) begin
         mdl[a]  = d;
         mval[a] = 1'b1;
      end
   endtask

   task automatic look(input logic [4:0] ik, input logic [4:0] fk, input string tag);
      step(1'b0, 4'd0, 16'd0, ik, fk, tag);
   endtask

   // monitor: compare just after the driver's negedge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            exp_t x;
            logic [15:0] ai, af;
            x  = sbq.pop_front();
            ai = {int_hit, int_idx, int_vec, int_ew, int_simd, int_bank, int_pred};
            af = {fp_hit, fp_idx, fp_vec, fp_ew, fp_simd, fp_bank, fp_pred};
            checks++;
            if (ai !== x.ires) begin
               errors++;
               $display("FAIL %s int port actual %h expected %h", x.tag, ai, x.ires);
            end
            checks++;
            if (af !== x.fres) begin
               errors++;
               $display("FAIL %s fp port actual %h expected %h", x.tag, af, x.fres);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mdl[i]  = '0;
         mval[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R7: empty table, defaults everywhere
      look(5'd0, 5'd0, "R1 reset key0");
      look(5'd31, 5'd31, "R1 reset key31");
      look(5'd3, 5'd17, "R7 miss defaults");

      // R2: write and look up the same key in one cycle
      step(1'b1, 4'd0, ent(1, 0, 1, 2'd2, 0, 5'd3, 5'd7), 5'd3, 5'd3, "R2 same-cycle old view");
      look(5'd3, 5'd3, "R3 int hit after write; R4 fp stays clear");

      // R8: floating-point entry for the same number, both ports together
      step(1'b1, 4'd1, ent(0, 0, 0, 2'd1, 1, 5'd3, 5'd12), 5'd3, 5'd3, "R2 fp write cycle");
      look(5'd3, 5'd3, "R8 both ports same key");
      look(5'd4, 5'd3, "R4 space separation");

      // R6: higher entry wins, lower one written later does not
      step(1'b1, 4'd5, ent(0, 0, 1, 2'd3, 0, 5'd3, 5'd21), 5'd3, 5'd0, "R2 write e5");
      look(5'd3, 5'd0, "R6 higher entry wins");
      step(1'b1, 4'd2, ent(1, 0, 0, 2'd0, 0, 5'd3, 5'd2), 5'd3, 5'd0, "R2 write e2");
      look(5'd3, 5'd3, "R6 lower entry written later loses");

      // R5: reserved bank never matches, even above a valid match
      step(1'b1, 4'd7, ent(1, 1, 1, 2'd1, 0, 5'd9, 5'd9), 5'd9, 5'd9, "R2 write reserved");
      look(5'd9, 5'd9, "R5 reserved bank ignored");
      step(1'b1, 4'd9, ent(1, 1, 1, 2'd2, 0, 5'd3, 5'd30), 5'd3, 5'd3, "R2 reserved above");
      look(5'd3, 5'd3, "R5 reserved high entry does not override");

      // R9: rewriting e5 with another key uncovers e2
      step(1'b1, 4'd5, ent(0, 0, 1, 2'd1, 0, 5'd10, 5'd11), 5'd3, 5'd10, "R2 rewrite e5");
      look(5'd3, 5'd10, "R9 old key now from e2");
      look(5'd10, 5'd10, "R9 new key hits int only");

      // boundary entry and key
      step(1'b1, 4'd15, ent(1, 0, 1, 2'd3, 1, 5'd31, 5'd31), 5'd31, 5'd31, "R2 top entry");
      look(5'd31, 5'd31, "R3 top entry top key");
      step(1'b1, 4'd14, ent(0, 0, 0, 2'd2, 1, 5'd31, 5'd1), 5'd0, 5'd31, "R2 e14");
      look(5'd0, 5'd31, "R6 e15 beats e14");

      // sweep all keys, both spaces, different keys per port
      for (int k = 0; k < 32; k++)
         look(5'(k), 5'(31 - k), "R8 sweep");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule